// File: doc/BRIEF.md
# Cascaded Interrupt Request Aggregator

This block gathers up to eighteen interrupt request lines from a slow legacy peripheral domain and merges them into one active-high request for a parent interrupt controller. Each line first crosses into the local clock domain through a two-flop synchronizer. A per-line polarity bit then conditions it, and a per-line state machine decides whether a request is pending. Software sees the pending requests in a status register and masks them with an enable register. It acknowledges a request by writing ones to a write-one-to-clear register. A control word holds the master switch and a choice between level and edge latching.

The register port is a simple single-cycle memory-mapped port. A write commits on the rising edge where `bus_sel` and `bus_wr` are both high. Read data is combinational from `bus_addr`.

Each line has two states. `LN_IDLE` means no request is latched. `LN_PEND` means a request is latched and shows as a one in status. The transition `set` goes from `LN_IDLE` to `LN_PEND`. It fires when the master switch is on and the conditioned line is active, in level mode, or has just become active, in edge mode. The transition `clear` goes from `LN_PEND` to `LN_IDLE`. It fires when software writes a one to that line's clear bit in a cycle where `set` is not also true.

Top module: `irq_gather_top`

## Requirements
- R1: The register offsets are as follows: 0x00 control, 0x04 enable, 0x08 status, 0x0C clear, 0x10 polarity. Any other offset reads as zero.
- R2: In control, bit 31 is the master enable and bit 30 selects edge latching (1) or level latching (0). All other control bits read zero. In enable, status and polarity, bits 31:18 read zero and bits 17:0 map to lines 17 to 0.
- R3: After reset, control, enable and status read zero, polarity reads 0x0003FFFF and `irq_out` is low.
- R4: A polarity bit of 1 makes its line active when high. A polarity bit of 0 makes its line active when low.
- R5: In level mode with the master enable on, an active line sets its status bit. The bit stays set after the line goes inactive, until it is cleared.
- R6: In edge mode, a status bit sets only when its conditioned line goes from inactive to active. A line held active after a clear does not set the bit again.
- R7: Writing a 1 to a clear bit clears that status bit, and writing a 0 leaves it unchanged. The clear register always reads as zero. A status bit falls only through such a write.
- R8: When a set and a clear reach the same bit in the same cycle, the bit stays set. A level-mode line held active therefore cannot be cleared.
- R9: `irq_out` is high exactly when the master enable is on and some bit is set in both enable and status.
- R10: With the master enable off, no status bit sets and `irq_out` stays low. Bits already set keep their value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | N_LINES | Raw request lines, asynchronous to clk |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| irq_out | output | 1 | Active-high cascade request to the parent controller |

## Verification
The assertions assume that `bus_addr` is a valid value, with no unknown bits, on every cycle outside reset. The read-data and clear-register properties evaluate it continuously. The bench therefore always drives a defined address, even when idle. The status-transition properties assume that the raw lines change no faster than once per several clocks, so each change reaches the line state machines as one clean transition. The bench changes a line only between register accesses and then waits at least four clocks before it reads status.

// File: rtl/irqg_pkg.sv
package irqg_pkg;

    // Byte offsets of the register file
    localparam int OFS_CTL = 'h00;
    localparam int OFS_ENA = 'h04;
    localparam int OFS_STS = 'h08;
    localparam int OFS_CLR = 'h0C;
    localparam int OFS_POL = 'h10;

    // Per-line request state
    typedef enum logic {
        LN_IDLE = 1'b0,
        LN_PEND = 1'b1
    } line_state_t;

endpackage

// File: rtl/irqg_sync.sv
module irqg_sync #(
    parameter int W      = 18,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= '0;
        end else begin
            stg[0] <= d_i;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign q_o = stg[STAGES-1];

endmodule

// File: rtl/irqg_regs.sv
module irqg_regs
    import irqg_pkg::*;
#(
    parameter int N_LINES = 18,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic [N_LINES-1:0] sts_i,
    output logic               ctl_en_o,
    output logic               ctl_edge_o,
    output logic [N_LINES-1:0] ena_o,
    output logic [N_LINES-1:0] pol_o,
    output logic [N_LINES-1:0] clr_o,
    output logic [DATA_W-1:0]  bus_rdata
);

    localparam int PAD_W = DATA_W - N_LINES;
    localparam int EN_B  = DATA_W - 1;
    localparam int EDG_B = DATA_W - 2;

    localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(OFS_CTL);
    localparam logic [ADDR_W-1:0] A_ENA = ADDR_W'(OFS_ENA);
    localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(OFS_STS);
    localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(OFS_CLR);
    localparam logic [ADDR_W-1:0] A_POL = ADDR_W'(OFS_POL);

    logic wr_stb;
    logic unused_wbits;

    assign wr_stb       = bus_sel && bus_wr;
    assign unused_wbits = ^bus_wdata[EDG_B-1:N_LINES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_en_o   <= 1'b0;
            ctl_edge_o <= 1'b0;
            ena_o      <= '0;
            pol_o      <= '1;
        end else if (wr_stb) begin
            if (bus_addr == A_CTL) begin
                ctl_en_o   <= bus_wdata[EN_B];
                ctl_edge_o <= bus_wdata[EDG_B];
            end
            if (bus_addr == A_ENA) ena_o <= bus_wdata[N_LINES-1:0];
            if (bus_addr == A_POL) pol_o <= bus_wdata[N_LINES-1:0];
        end
    end

    // One-cycle write-one-to-clear pulse vector
    assign clr_o = (wr_stb && bus_addr == A_CLR) ? bus_wdata[N_LINES-1:0] : '0;

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_CTL:   begin
                         bus_rdata[EN_B]  = ctl_en_o;
                         bus_rdata[EDG_B] = ctl_edge_o;
                     end
            A_ENA:   bus_rdata = {{PAD_W{1'b0}}, ena_o};
            A_STS:   bus_rdata = {{PAD_W{1'b0}}, sts_i};
            A_POL:   bus_rdata = {{PAD_W{1'b0}}, pol_o};
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/irqg_line.sv
module irqg_line
    import irqg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic act_i,
    input  logic gen_en_i,
    input  logic edge_mode_i,
    input  logic clr_i,
    output logic pend_o
);

    line_state_t state_q, state_d;
    logic        act_q;
    logic        hit;

    // Request qualifier: level or rising transition, gated by master enable
    assign hit = gen_en_i && (edge_mode_i ? (act_i && !act_q) : act_i);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LN_IDLE: if (hit)            state_d = LN_PEND;
            LN_PEND: if (clr_i && !hit)  state_d = LN_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LN_IDLE;
            act_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            act_q   <= act_i;
        end
    end

    always_comb begin
        pend_o = (state_q == LN_PEND);
    end

endmodule

// File: rtl/irq_gather_top.sv
module irq_gather_top
    import irqg_pkg::*;
#(
    parameter int N_LINES     = 18,
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irq_lines,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_out
);

    logic [N_LINES-1:0] line_sync;
    logic [N_LINES-1:0] line_act;
    logic [N_LINES-1:0] sts_vec;
    logic [N_LINES-1:0] ena_vec;
    logic [N_LINES-1:0] pol_vec;
    logic [N_LINES-1:0] clr_vec;
    logic               ctl_en;
    logic               ctl_edge;

    irqg_sync #(.W(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (irq_lines),
        .q_o   (line_sync)
    );

    irqg_regs #(.N_LINES(N_LINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .sts_i      (sts_vec),
        .ctl_en_o   (ctl_en),
        .ctl_edge_o (ctl_edge),
        .ena_o      (ena_vec),
        .pol_o      (pol_vec),
        .clr_o      (clr_vec),
        .bus_rdata  (bus_rdata)
    );

    // Polarity 1: high is active; polarity 0: low is active
    assign line_act = ~(line_sync ^ pol_vec);

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        irqg_line u_line (
            .clk         (clk),
            .rst_n       (rst_n),
            .act_i       (line_act[i]),
            .gen_en_i    (ctl_en),
            .edge_mode_i (ctl_edge),
            .clr_i       (clr_vec[i]),
            .pend_o      (sts_vec[i])
        );
    end

    assign irq_out = ctl_en && |(ena_vec & sts_vec);

endmodule

// File: rtl/irqg_checker.sv
module irqg_checker
    import irqg_pkg::*;
#(
    parameter int N_LINES = 18,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_sel,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic               gen_en,
    input logic [N_LINES-1:0] sts,
    input logic               irq_out
);

    logic clr_wr;
    assign clr_wr = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_CLR));

    AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-3:N_LINES] == '0); // R2

    AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFS_CLR)) |-> (bus_rdata == '0)); // R7

    AST_STS_FALL_ON_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(sts) & ~sts)) |-> $past(clr_wr)); // R7

    AST_STS_RISE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (|(sts & ~$past(sts))) |-> $past(gen_en)); // R10

    AST_OUT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> gen_en); // R9

    AST_OUT_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (|sts)); // R9

endmodule

bind irq_gather_top irqg_checker #(
    .N_LINES (N_LINES),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .gen_en    (ctl_en),
    .sts       (sts_vec),
    .irq_out   (irq_out)
);

// File: tb/irq_gather_top_bench.sv
module irq_gather_top_bench;

    localparam int N  = 18;
    localparam int DW = 32;
    localparam int AW = 5;

    localparam logic [AW-1:0] A_CTL = 5'h00;
    localparam logic [AW-1:0] A_ENA = 5'h04;
    localparam logic [AW-1:0] A_STS = 5'h08;
    localparam logic [AW-1:0] A_CLR = 5'h0C;
    localparam logic [AW-1:0] A_POL = 5'h10;

    typedef struct {
        logic [DW-1:0] d;
        logic          c;
        string         tag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_lines = '0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          irq_out;

    item_t exp_q[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;

    always #4 clk = ~clk;

    irq_gather_top u_irq_gather_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_lines (irq_lines),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic expect_rd(input logic [AW-1:0] a, input logic [DW-1:0] d,
                             input logic c, input string tag);
        item_t it;
        @(posedge clk); #1;
        bus_addr = a;
        it.d = d; it.c = c; it.tag = tag;
        exp_q.push_back(it);
        while (exp_q.size() != 0) @(posedge clk);
    endtask

    task automatic settle();
        repeat (5) @(posedge clk);
    endtask

    // Monitor: pops expected items and compares at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                item_t it;
                it = exp_q.pop_front();
                n_cmp++;
                if (bus_rdata !== it.d || irq_out !== it.c) begin
                    n_bad++;
                    $display("FAIL %s: rdata=%h irq_out=%b expected rdata=%h irq_out=%b",
                             it.tag, bus_rdata, irq_out, it.d, it.c);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R3 reset values, R1 offsets
        expect_rd(A_CTL, 32'h0, 1'b0, "R3 ctrl reset");
        expect_rd(A_ENA, 32'h0, 1'b0, "R3 enable reset");
        expect_rd(A_STS, 32'h0, 1'b0, "R3 status reset");
        expect_rd(A_POL, 32'h0003FFFF, 1'b0, "R3 polarity reset");
        expect_rd(A_CLR, 32'h0, 1'b0, "R7 clear reads zero");
        expect_rd(5'h14, 32'h0, 1'b0, "R1 unmapped offset");

        // R10 master off: nothing latches
        irq_lines[0] = 1'b1;
        settle();
        expect_rd(A_STS, 32'h0, 1'b0, "R10 no latch while disabled");
        irq_lines[0] = 1'b0;
        settle();

        // R2 control and enable field widths
        wr(A_CTL, 32'h8000FFFF);
        expect_rd(A_CTL, 32'h80000000, 1'b0, "R2 ctrl bits");
        wr(A_ENA, 32'hFFFFFFFF);
        expect_rd(A_ENA, 32'h0003FFFF, 1'b0, "R2 enable width");

        // R5 level latching, R8 set beats clear, R7 clear semantics, R9 output
        irq_lines[3] = 1'b1;
        settle();
        expect_rd(A_STS, 32'h8, 1'b1, "R5 level sets, R9 out high");
        wr(A_CLR, 32'h8);
        expect_rd(A_STS, 32'h8, 1'b1, "R8 clear while active loses");
        irq_lines[3] = 1'b0;
        settle();
        expect_rd(A_STS, 32'h8, 1'b1, "R5 held after release");
        wr(A_CLR, 32'h0);
        expect_rd(A_STS, 32'h8, 1'b1, "R7 zero write keeps bit");
        wr(A_CLR, 32'h8);
        expect_rd(A_STS, 32'h0, 1'b0, "R7 one write clears");

        // R9 masking
        wr(A_ENA, 32'h0003FFDF);
        irq_lines[5] = 1'b1;
        settle();
        expect_rd(A_STS, 32'h20, 1'b0, "R9 masked line no output");
        wr(A_ENA, 32'h0003FFFF);
        expect_rd(A_STS, 32'h20, 1'b1, "R9 unmask raises output");
        irq_lines[5] = 1'b0;
        settle();
        wr(A_CLR, 32'h20);
        expect_rd(A_STS, 32'h0, 1'b0, "R7 clear line 5");

        // R4 active-low line 7
        irq_lines[7] = 1'b1;
        settle();
        expect_rd(A_STS, 32'h80, 1'b1, "R4 high active with pol 1");
        wr(A_POL, 32'h0003FF7F);
        settle();
        wr(A_CLR, 32'h80);
        expect_rd(A_STS, 32'h0, 1'b0, "R4 high inactive with pol 0");
        irq_lines[7] = 1'b0;
        settle();
        expect_rd(A_STS, 32'h80, 1'b1, "R4 low active with pol 0");
        irq_lines[7] = 1'b1;
        settle();
        wr(A_CLR, 32'h80);
        expect_rd(A_STS, 32'h0, 1'b0, "R4 cleared after release");

        // R6 edge mode
        wr(A_CTL, 32'hC0000000);
        expect_rd(A_CTL, 32'hC0000000, 1'b0, "R2 edge bit reads back");
        irq_lines[2] = 1'b1;
        settle();
        expect_rd(A_STS, 32'h4, 1'b1, "R6 rising edge sets");
        wr(A_CLR, 32'h4);
        settle();
        expect_rd(A_STS, 32'h0, 1'b0, "R6 held line no reset");
        irq_lines[2] = 1'b0;
        settle();
        irq_lines[2] = 1'b1;
        settle();
        expect_rd(A_STS, 32'h4, 1'b1, "R6 second edge sets");

        // R10 master off keeps bits, holds output low
        wr(A_CTL, 32'h0);
        expect_rd(A_STS, 32'h4, 1'b0, "R10 bits kept, output low");
        irq_lines[9] = 1'b1;
        settle();
        expect_rd(A_STS, 32'h4, 1'b0, "R10 new line ignored");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule